// File: doc/BRIEF.md
# Tag Binary-Tree Anticollision Engine

This block is the decision core of a passive tag taking part in a binary-tree search for singulation. It receives commands that a frame decoder has already validated, one per `cmd_valid` strobe. It keeps an 8-bit slot counter and a pseudo-random bit. From these it decides, for every command, whether the tag stays silent, answers with its 64-bit identifier, or answers with its data. Serialising and encoding the answer is the job of downstream logic.

Group membership comes from a masked less-than comparison. Eight consecutive bytes of a small constant memory are compared against the command's 64-bit data field. Once a tag is selected, fail and success commands spread the tags over slots. Each tag answers only while its counter is zero. A data-read command naming the tag's identifier moves it into data exchange, and the tag stays there until reset.

Top module: `tag_anticoll`

## Requirements
- R1: While `rst_n` is low, `tag_state` is 0 (powered off) and `resp_req` is 0. On the first clock edge after reset is released, `tag_state` becomes 1 (ready). State codes: 0 off, 1 ready, 2 identify, 3 data exchange.
- R2: In ready, opcode 0x03 compares two 64-bit values. The first is built from memory bytes at indices (addr+j) mod MEM_BYTES for j=0..7, with byte j=0 most significant. The second is `cmd_data`, with byte j at bits [63-8j -: 8]. Memory byte i holds (MEM_BASE + i*MEM_STEP) mod 256. If the memory value is strictly smaller, the tag enters identify with counter 0 and answers with its identifier. Otherwise it stays ready and silent.
- R3: Mask bit j enables byte j in the comparison of R2. A disabled byte counts as equal, so mask 0 never selects.
- R4: Opcode 0x04 moves a tag from identify to ready, silently. The tag leaves identify for ready in no other way, and 0x04 has no effect in ready or data exchange.
- R5: Opcode 0x08 increments a nonzero counter, saturating at 255, silently.
- R6: Opcode 0x08 with the counter at zero draws a random bit. One outcome keeps the counter at 0 and answers with the identifier. The other sets the counter to 1 and stays silent.
- R7: Opcode 0x09 decrements a nonzero counter. The tag answers with its identifier exactly when the counter goes from 1 to 0. A counter already at 0 stays 0, and the tag stays silent.
- R8: Opcode 0x0A makes a tag in identify whose counter is zero answer with its identifier, without changing the counter. With a nonzero counter it is silent.
- R9: Opcode 0x0C moves a tag in identify to data exchange and answers with data, but only when `cmd_uid` equals `tag_uid`. A mismatch has no effect. In data exchange, only 0x0C with a matching identifier produces a response (data again). The tag leaves data exchange only through reset.
- R10: A response appears as `resp_req` high for exactly the one cycle following the clock edge that accepted the command. `resp_kind` is 1 for identifier, 2 for data, and 0 when there is no response.
- R11: The random bit comes from a 16-bit maximal-length LFSR that advances every clock and is never zero. Over repeated draws, both outcomes of R6 occur.
- R12: Other opcodes, and any command other than 0x03 in ready, change nothing and produce no response. Opcode 0x03 in identify is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-off) |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_op | input | 8 | Command opcode |
| cmd_addr | input | 8 | Memory start address for select |
| cmd_mask | input | 8 | Byte enable mask for select |
| cmd_data | input | 64 | Comparison data for select |
| cmd_uid | input | 64 | Identifier carried by data read |
| tag_uid | input | 64 | This tag's own identifier |
| resp_req | output | 1 | Request to transmit a reply |
| resp_kind | output | 2 | Reply type: 0 none, 1 identifier, 2 data |
| tag_state | output | 2 | Current state code |

## Verification
The assertions check on every cycle that:
- a response only follows an accepted command;
- the powered-off state is never re-entered and data exchange is never left;
- the tag returns from identify to ready only on an unselect command, and enters data exchange only on an identifier match;
- the counter holds at 255 under further increments;
- the random source never locks at zero.

Only the bench scenarios can show the numeric effects:
- the masked comparison result for given memory contents;
- the counter's value as revealed by the exact success command that makes the tag answer;
- both random outcomes after a fail;
- the one-cycle width of each reply.

// File: rtl/tag_ac_pkg.sv
// Shared encodings for the tag anticollision engine.
// Assumes opcodes arrive already decoded and CRC-checked.
package tag_ac_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_READY = 2'd1,
        ST_IDENT = 2'd2,
        ST_DATA  = 2'd3
    } tag_state_t;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_UID  = 2'd1,
        RK_DATA = 2'd2
    } resp_kind_t;

    localparam logic [7:0] OP_SEL_LT  = 8'h03;
    localparam logic [7:0] OP_UNSEL   = 8'h04;
    localparam logic [7:0] OP_FAIL    = 8'h08;
    localparam logic [7:0] OP_SUCCESS = 8'h09;
    localparam logic [7:0] OP_RESEND  = 8'h0A;
    localparam logic [7:0] OP_DREAD   = 8'h0C;
endpackage

// File: rtl/tag_ac_lfsr.sv
// Free-running 16-bit Fibonacci LFSR (x^16+x^14+x^13+x^11+1).
// Assumes: a zero seed parameter is replaced by 1 so the register never locks up.
module tag_ac_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] state_q,
    output logic        rnd_bit
);
    localparam logic [15:0] SEED_SAFE = (SEED == 16'h0) ? 16'h0001 : SEED;

    logic feedback;
    assign feedback = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];
    assign rnd_bit  = state_q[0];

    // Advance one step every clock, reload the seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED_SAFE;
        else        state_q <= {state_q[14:0], feedback};
    end
endmodule

// File: rtl/tag_ac_slot.sv
// Saturating slot counter: clear wins over increment, which wins over decrement.
// Assumes at most one of inc/dec is asserted by the controller in a cycle.
module tag_ac_slot #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Update the counter, holding at the top and bottom limits.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (clr)                        cnt_q <= '0;
        else if (inc && cnt_q != CNT_MAX)    cnt_q <= cnt_q + 1'b1;
        else if (dec && cnt_q != '0)         cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/tag_ac_cmp.sv
// Masked, most-significant-first less-than comparator against a constant byte memory.
// Memory byte i = (MEM_BASE + i*MEM_STEP) mod 256; MEM_BYTES must be a power of two.
module tag_ac_cmp #(
    parameter int MEM_BYTES = 16,
    parameter int MEM_BASE  = 'h10,
    parameter int MEM_STEP  = 'h11,
    parameter int NBYTES    = 8
) (
    input  logic [7:0]          addr,
    input  logic [NBYTES-1:0]   mask,
    input  logic [8*NBYTES-1:0] data,
    output logic                mem_lt
);
    localparam int AW = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;

    logic [7:0] mem [MEM_BYTES];

    genvar gi;
    generate
        for (gi = 0; gi < MEM_BYTES; gi++) begin : g_mem
            assign mem[gi] = 8'((MEM_BASE + gi * MEM_STEP) % 256);
        end
    endgenerate

    // First enabled byte that differs decides the comparison.
    always_comb begin
        logic       decided;
        logic [7:0] a_idx;
        logic [7:0] m_b;
        logic [7:0] d_b;
        mem_lt  = 1'b0;
        decided = 1'b0;
        for (int j = 0; j < NBYTES; j++) begin
            a_idx = addr + 8'(j);
            m_b   = mem[a_idx[AW-1:0]];
            d_b   = data[8*(NBYTES-1-j) +: 8];
            if (!decided && mask[j] && (m_b != d_b)) begin
                decided = 1'b1;
                mem_lt  = (m_b < d_b);
            end
        end
    end
endmodule

// File: rtl/tag_anticoll.sv
// Tag-side binary-tree anticollision controller.
// Takes one decoded command per cmd_valid; registers the reply request one cycle later.
// Assumes the memory behind group select is constant and local (see tag_ac_cmp).
module tag_anticoll
    import tag_ac_pkg::*;
#(
    parameter int          CNT_W     = 8,
    parameter int          MEM_BYTES = 16,
    parameter int          MEM_BASE  = 'h10,
    parameter int          MEM_STEP  = 'h11,
    parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [7:0]  cmd_op,
    input  logic [7:0]  cmd_addr,
    input  logic [7:0]  cmd_mask,
    input  logic [63:0] cmd_data,
    input  logic [63:0] cmd_uid,
    input  logic [63:0] tag_uid,
    output logic        resp_req,
    output logic [1:0]  resp_kind,
    output logic [1:0]  tag_state
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    tag_state_t       state_q, state_n;
    resp_kind_t       kind_q, kind_n;
    logic [CNT_W-1:0] slot_q;
    logic             slot_clr, slot_inc, slot_dec;
    logic [15:0]      rnd_state;
    logic             rnd_bit;
    logic             mem_lt;
    logic             uid_hit;

    tag_ac_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .state_q(rnd_state), .rnd_bit(rnd_bit)
    );

    tag_ac_slot #(.CNT_W(CNT_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .clr(slot_clr), .inc(slot_inc),
        .dec(slot_dec), .cnt_q(slot_q)
    );

    tag_ac_cmp #(
        .MEM_BYTES(MEM_BYTES), .MEM_BASE(MEM_BASE), .MEM_STEP(MEM_STEP), .NBYTES(8)
    ) u_cmp (
        .addr(cmd_addr), .mask(cmd_mask), .data(cmd_data), .mem_lt(mem_lt)
    );

    assign uid_hit = (cmd_uid == tag_uid);

    // Decide next state, counter action and reply for the current command.
    always_comb begin
        state_n  = state_q;
        kind_n   = RK_NONE;
        slot_clr = 1'b0;
        slot_inc = 1'b0;
        slot_dec = 1'b0;
        unique case (state_q)
            ST_OFF: state_n = ST_READY;
            ST_READY: begin
                if (cmd_valid && cmd_op == OP_SEL_LT && mem_lt) begin
                    state_n  = ST_IDENT;
                    slot_clr = 1'b1;
                    kind_n   = RK_UID;
                end
            end
            ST_IDENT: begin
                if (cmd_valid) begin
                    case (cmd_op)
                        OP_UNSEL: state_n = ST_READY;
                        OP_FAIL: begin
                            if (slot_q != '0 || rnd_bit) slot_inc = 1'b1;
                            else                         kind_n   = RK_UID;
                        end
                        OP_SUCCESS: begin
                            slot_dec = 1'b1;
                            if (slot_q == CNT_ONE) kind_n = RK_UID;
                        end
                        OP_RESEND: begin
                            if (slot_q == '0) kind_n = RK_UID;
                        end
                        OP_DREAD: begin
                            if (uid_hit) begin
                                state_n = ST_DATA;
                                kind_n  = RK_DATA;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_DATA: begin
                if (cmd_valid && cmd_op == OP_DREAD && uid_hit) kind_n = RK_DATA;
            end
            default: state_n = ST_OFF;
        endcase
    end

    // Register state and reply; reset means power-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            kind_q  <= RK_NONE;
        end else begin
            state_q <= state_n;
            kind_q  <= kind_n;
        end
    end

    assign resp_req  = (kind_q != RK_NONE);
    assign resp_kind = kind_q;
    assign tag_state = state_q;
endmodule

// File: rtl/tag_anticoll_chk.sv
// Property checker for tag_anticoll, attached by bind below.
// Assumes the default 8-bit counter width for the saturation value.
module tag_anticoll_chk
    import tag_ac_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [7:0]       cmd_op,
    input logic [63:0]      cmd_uid,
    input logic [63:0]      tag_uid,
    input logic             resp_req,
    input logic [1:0]       resp_kind,
    input logic [1:0]       tag_state,
    input logic [CNT_W-1:0] slot_q,
    input logic             slot_inc,
    input logic [15:0]      rnd_state
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R10
    resp_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_req |-> $past(cmd_valid));

    // R1
    no_return_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_state != 2'(ST_OFF)) |=> (tag_state != 2'(ST_OFF)));

    // R9
    data_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_state == 2'(ST_DATA)) |=> (tag_state == 2'(ST_DATA)));

    // R9
    data_reply_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_kind == 2'(RK_DATA)) |-> (tag_state == 2'(ST_DATA)));

    // R9
    data_entry_uid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_state == 2'(ST_DATA) && $past(tag_state) != 2'(ST_DATA))
        |-> ($past(cmd_uid) == $past(tag_uid)));

    // R4
    unsel_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_state == 2'(ST_READY) && $past(tag_state) == 2'(ST_IDENT))
        |-> ($past(cmd_valid) && $past(cmd_op) == OP_UNSEL));

    // R5
    slot_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == CNT_MAX && slot_inc) |=> (slot_q == CNT_MAX));

    // R11
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_state != 16'h0);
endmodule

bind tag_anticoll tag_anticoll_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_uid(cmd_uid), .tag_uid(tag_uid), .resp_req(resp_req),
    .resp_kind(resp_kind), .tag_state(tag_state), .slot_q(slot_q),
    .slot_inc(slot_inc), .rnd_state(rnd_state)
);

// File: tb/tag_anticoll_bench.sv
// Self-checking bench: directed corners, then seeded random command streams
// checked against a reference model of the slot counter and state.
module tag_anticoll_bench;
    localparam int MEM_BYTES = 16;
    localparam int MEM_BASE  = 'h10;
    localparam int MEM_STEP  = 'h11;
    localparam logic [63:0] MY_UID = 64'hC0FF_EE12_3456_789A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = '0;
    logic [7:0]  cmd_addr = '0;
    logic [7:0]  cmd_mask = '0;
    logic [63:0] cmd_data = '0;
    logic [63:0] cmd_uid = '0;
    logic        resp_req;
    logic [1:0]  resp_kind;
    logic [1:0]  tag_state;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int m_state = 0;
    int m_cnt = 0;
    int seen_stay = 0;
    int seen_move = 0;

    always #2.5 clk = ~clk;

    tag_anticoll u_tag_anticoll (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_mask(cmd_mask), .cmd_data(cmd_data),
        .cmd_uid(cmd_uid), .tag_uid(MY_UID), .resp_req(resp_req),
        .resp_kind(resp_kind), .tag_state(tag_state)
    );

    function automatic logic [7:0] mem_byte(input int i);
        return 8'((MEM_BASE + (i % MEM_BYTES) * MEM_STEP) % 256);
    endfunction

    // Expected outcome of the masked less-than select (R2, R3).
    function automatic bit exp_lt(input logic [7:0] a, input logic [7:0] m, input logic [63:0] d);
        for (int j = 0; j < 8; j++) begin
            logic [7:0] mb;
            logic [7:0] db;
            mb = mem_byte((int'(a) + j) % 256);
            db = d[63-8*j -: 8];
            if (m[j] && mb != db) return (mb < db);
        end
        return 1'b0;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset state", 64'(tag_state), 0);
        check("R1 reset resp", 64'(resp_req), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 ready after reset", 64'(tag_state), 1);
        m_state = 1;
        m_cnt = 0;
    endtask

    // Issue one command, capture the reply, then confirm the reply lasts one cycle.
    task automatic send(input logic [7:0] op, input logic [7:0] a, input logic [7:0] m,
                        input logic [63:0] d, input logic [63:0] u,
                        output logic [1:0] k, output logic [1:0] s);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_mask = m; cmd_data = d; cmd_uid = u;
        @(posedge clk); #1;
        k = resp_kind;
        s = tag_state;
        check("R10 req matches kind", 64'(resp_req), 64'(resp_kind != 2'd0));
        @(negedge clk);
        cmd_valid = 1'b0;
        @(posedge clk); #1;
        check("R10 one-cycle reply", 64'(resp_req), 0);
    endtask

    // Apply a command to the model and the design and compare.
    task automatic step(input logic [7:0] op, input logic [7:0] a, input logic [7:0] m,
                        input logic [63:0] d, input logic [63:0] u, input string req);
        int ek;
        logic [1:0] k;
        logic [1:0] s;
        ek = 0;
        send(op, a, m, d, u, k, s);
        if (m_state == 1) begin
            if (op == 8'h03 && exp_lt(a, m, d)) begin m_state = 2; m_cnt = 0; ek = 1; end
        end else if (m_state == 2) begin
            case (op)
                8'h04: m_state = 1;
                8'h08: begin
                    if (m_cnt != 0) begin
                        if (m_cnt < 255) m_cnt++;
                    end else begin
                        // R6: either outcome is legal; learn which one from the reply.
                        check("R6 fail-at-zero reply", 64'(k == 2'd0 || k == 2'd1), 1);
                        if (k == 2'd1) begin ek = 1; seen_stay++; end
                        else begin m_cnt = 1; seen_move++; end
                    end
                end
                8'h09: if (m_cnt != 0) begin m_cnt--; if (m_cnt == 0) ek = 1; end
                8'h0A: if (m_cnt == 0) ek = 1;
                8'h0C: if (u == MY_UID) begin m_state = 3; ek = 2; end
                default: ;
            endcase
        end else if (m_state == 3) begin
            if (op == 8'h0C && u == MY_UID) ek = 2;
        end
        check({req, " kind"}, 64'(k), 64'(ek));
        check({req, " state"}, 64'(s), 64'(m_state));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4217));
        do_reset();

        // R12: unknown opcode and non-select commands in ready are ignored.
        step(8'h55, 0, 8'hFF, '1, MY_UID, "R12 unknown op");
        step(8'h0C, 0, 8'hFF, '1, MY_UID, "R12 dataread in ready");
        step(8'h04, 0, 8'hFF, '1, MY_UID, "R4 unsel in ready");
        // R3: empty mask never selects; mask on an equal byte only is not less.
        step(8'h03, 8'h0F, 8'h00, '1, 0, "R3 mask zero");
        step(8'h03, 8'h00, 8'h01, {mem_byte(0), 56'h0}, 0, "R3 equal masked byte");
        // R2: memory not smaller stays silent; smaller selects.
        step(8'h03, 8'h00, 8'hFF, '0, 0, "R2 not less");
        step(8'h03, 8'h0F, 8'hFF, '1, 0, "R2 select less");
        step(8'h03, 8'h00, 8'hFF, '1, 0, "R12 select in ident");
        step(8'h0A, 0, 0, 0, 0, "R8 resend at zero");
        step(8'h09, 0, 0, 0, 0, "R7 success at zero");
        // R6/R5: push the counter off zero, then saturate it.
        for (int i = 0; i < 64 && m_cnt == 0; i++) step(8'h08, 0, 0, 0, 0, "R6 fail draw");
        check("R6 counter left zero", 64'(m_cnt), 1);
        step(8'h0A, 0, 0, 0, 0, "R8 resend nonzero");
        for (int i = 0; i < 300; i++) step(8'h08, 0, 0, 0, 0, "R5 fail saturate");
        for (int i = 0; i < 255; i++) step(8'h09, 0, 0, 0, 0, "R7 success countdown");
        check("R5 saturated count drained", 64'(m_cnt), 0);
        step(8'h0C, 0, 0, 0, ~MY_UID, "R9 uid mismatch");
        step(8'h04, 0, 0, 0, 0, "R4 unsel from ident");
        step(8'h03, 8'h0F, 8'hFF, '1, 0, "R2 reselect");
        step(8'h0C, 0, 0, 0, MY_UID, "R9 dataread match");
        step(8'h04, 0, 0, 0, 0, "R4 unsel in data");
        step(8'h08, 0, 0, 0, 0, "R9 fail in data");
        step(8'h0C, 0, 0, 0, MY_UID, "R9 dataread again");

        // Random phase.
        for (int n = 0; n < 3000; n++) begin
            int r;
            logic [7:0] op;
            logic [63:0] u;
            if (m_state == 3 && ($urandom % 4) == 0) do_reset();
            r = $urandom % 20;
            if (r < 4)       op = 8'h03;
            else if (r < 9)  op = 8'h08;
            else if (r < 14) op = 8'h09;
            else if (r < 16) op = 8'h0A;
            else if (r < 17) op = 8'h04;
            else if (r < 19) op = 8'h0C;
            else             op = 8'($urandom);
            u = (($urandom % 3) == 0) ? MY_UID : {$urandom, $urandom};
            step(op, 8'($urandom), 8'($urandom), {$urandom, $urandom}, u, "R2 R7 random");
        end
        check("R11 stay outcome seen", 64'(seen_stay > 0), 1);
        check("R11 move outcome seen", 64'(seen_move > 0), 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule